// File: doc/BRIEF.md
# Integer ALU with Shifts

This block is the integer execute unit of a load/store RISC pipeline. Each cycle it takes two 32-bit operands, a 5-bit shift count and a 6-bit function code. From these it forms one result: a sum or difference, a bitwise combination, a 0/1 comparison value, a shifted word or an upper-half constant. The result and an overflow-exception flag are registered, so they appear one clock after the inputs are presented.

There is no flags register. A comparison writes 0 or 1 into the ordinary result word. Only the signed add and signed subtract codes can raise the overflow exception. Their unsigned twins produce the same bits and never raise it. Operand selection, immediate extension, branch decisions and the register file belong to neighbouring blocks.

Top module: `alu_core`

## Requirements
- R1: While `rst_n` is low, `result_o` is 0 and `ovf_o` is 0, whatever the inputs are.
- R2: Function codes 0x20 (signed add) and 0x21 (unsigned add) give `opa_i + opb_i` modulo 2^32 on `result_o` one clock after the inputs.
- R3: Function codes 0x22 (signed subtract) and 0x23 (unsigned subtract) give `opa_i - opb_i` modulo 2^32.
- R4: `ovf_o` is 1 only after code 0x20 or 0x22 whose two's-complement result overflowed. Codes 0x21 and 0x23 never set it. The wrapped value is still output.
- R5: Codes 0x24, 0x25 and 0x26 give the bitwise AND, OR and XOR of the operands.
- R6: Code 0x27 gives the complement of the bitwise OR of the operands.
- R7: Code 0x2A gives 1 when `opa_i` is less than `opb_i` as signed values, else 0. This holds even when the internal difference overflows, and it never sets `ovf_o`.
- R8: Code 0x2B gives 1 when `opa_i` is less than `opb_i` as unsigned values, else 0.
- R9: Code 0x00 shifts `opa_i` left by `shamt_i` (0 to 31) and code 0x02 shifts it right by `shamt_i`. Both fill vacated bits with zeros, and a count of 0 passes the operand unchanged.
- R10: Code 0x03 shifts `opa_i` right by `shamt_i`, filling vacated bits with copies of bit 31.
- R11: Code 0x0F puts `opb_i[15:0]` into result bits 31:16 and clears bits 15:0.
- R12: Any other function code gives a result of 0 and `ovf_o` of 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; result and flag register on the rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| func_i | input | 6 | Function code selecting the operation |
| opa_i | input | 32 | First operand; also the value that is shifted |
| opb_i | input | 32 | Second operand; low half is the upper-immediate constant |
| shamt_i | input | 5 | Shift count |
| result_o | output | 32 | Registered result word |
| ovf_o | output | 1 | Registered overflow-exception flag |

## Verification
The wrapped arithmetic result and the overflow exception are produced in the same cycle by the same shared adder, so they can be wrong together. The bench provokes this with operand pairs at the signed limits, such as 0x7FFFFFFF plus 1 and 0x80000000 minus 1. It sends each pair once with the signed code and once with the unsigned code. At each sample it compares the result word and the flag together. The same result must appear under both codes, and only the signed code may raise the flag. The signed comparison uses the same overflowing subtraction and is checked to return the correct order without raising the flag.

// File: rtl/alu_pkg.sv
package alu_pkg;

    localparam int FUNC_W = 6;

    typedef enum logic [FUNC_W-1:0] {
        FN_SHL  = 6'h00,
        FN_SHR  = 6'h02,
        FN_SHRA = 6'h03,
        FN_UPIM = 6'h0F,
        FN_ADDS = 6'h20,
        FN_ADDW = 6'h21,
        FN_SUBS = 6'h22,
        FN_SUBW = 6'h23,
        FN_AND  = 6'h24,
        FN_OR   = 6'h25,
        FN_XOR  = 6'h26,
        FN_NOR  = 6'h27,
        FN_LTS  = 6'h2A,
        FN_LTU  = 6'h2B
    } alu_func_e;

    // Low two bits of the bitwise codes select the combination
    typedef enum logic [1:0] {
        BW_AND = 2'b00,
        BW_OR  = 2'b01,
        BW_XOR = 2'b10,
        BW_NOR = 2'b11
    } bitwise_op_e;

endpackage

// File: rtl/alu_addsub.sv
module alu_addsub #(
    parameter int WIDTH = 32
) (
    input  logic [WIDTH-1:0] a_i,
    input  logic [WIDTH-1:0] b_i,
    input  logic             sub_i,
    output logic [WIDTH-1:0] sum_o,
    output logic             ovf_o,
    output logic             lt_signed_o,
    output logic             lt_unsigned_o
);

    logic [WIDTH-1:0] b_eff;
    logic [WIDTH:0]   wide_sum;

    always_comb begin
        b_eff    = sub_i ? ~b_i : b_i;
        wide_sum = {1'b0, a_i} + {1'b0, b_eff} + {{WIDTH{1'b0}}, sub_i};
        sum_o    = wide_sum[WIDTH-1:0];
        // Same-sign inputs giving an opposite-sign sum means overflow
        ovf_o    = (a_i[WIDTH-1] == b_eff[WIDTH-1]) &&
                   (sum_o[WIDTH-1] != a_i[WIDTH-1]);
        lt_signed_o   = sum_o[WIDTH-1] ^ ovf_o;
        lt_unsigned_o = ~wide_sum[WIDTH];
    end

endmodule

// File: rtl/alu_bitwise.sv
module alu_bitwise
    import alu_pkg::*;
#(
    parameter int WIDTH = 32
) (
    input  logic [WIDTH-1:0] a_i,
    input  logic [WIDTH-1:0] b_i,
    input  bitwise_op_e      op_i,
    output logic [WIDTH-1:0] y_o
);

    always_comb begin
        case (op_i)
            BW_AND:  y_o = a_i & b_i;
            BW_OR:   y_o = a_i | b_i;
            BW_XOR:  y_o = a_i ^ b_i;
            default: y_o = ~(a_i | b_i);
        endcase
    end

endmodule

// File: rtl/alu_shifter.sv
module alu_shifter #(
    parameter int WIDTH   = 32,
    parameter int SHAMT_W = $clog2(WIDTH)
) (
    input  logic [WIDTH-1:0]   d_i,
    input  logic [SHAMT_W-1:0] amt_i,
    input  logic               left_i,
    input  logic               arith_i,
    output logic [WIDTH-1:0]   y_o
);

    logic [WIDTH-1:0] d_rev;
    logic [WIDTH-1:0] stage [SHAMT_W+1];
    logic [WIDTH-1:0] out_rev;
    logic             fill;

    // Left shifts reuse the right shifter on a bit-reversed word
    for (genvar i = 0; i < WIDTH; i++) begin : g_rev
        assign d_rev[i]   = d_i[WIDTH-1-i];
        assign out_rev[i] = stage[SHAMT_W][WIDTH-1-i];
    end

    assign fill     = arith_i & ~left_i & d_i[WIDTH-1];
    assign stage[0] = left_i ? d_rev : d_i;

    for (genvar s = 0; s < SHAMT_W; s++) begin : g_stage
        localparam int STEP = 1 << s;
        assign stage[s+1] = amt_i[s]
            ? {{STEP{fill}}, stage[s][WIDTH-1:STEP]}
            : stage[s];
    end

    assign y_o = left_i ? out_rev : stage[SHAMT_W];

endmodule

// File: rtl/alu_core.sv
module alu_core
    import alu_pkg::*;
#(
    parameter int WIDTH = 32
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [FUNC_W-1:0]      func_i,
    input  logic [WIDTH-1:0]       opa_i,
    input  logic [WIDTH-1:0]       opb_i,
    input  logic [$clog2(WIDTH)-1:0] shamt_i,
    output logic [WIDTH-1:0]       result_o,
    output logic                   ovf_o
);

    localparam int SHAMT_W = $clog2(WIDTH);
    localparam int IMM_W   = WIDTH / 2;

    typedef struct packed {
        logic [WIDTH-1:0] result;
        logic             ovf;
    } alu_out_t;

    alu_out_t    out_d, out_q;
    alu_func_e   fn;
    logic        sub_en, sh_left, sh_arith;
    bitwise_op_e bw_op;

    logic [WIDTH-1:0] as_sum, bw_y, sh_y;
    logic             as_ovf, as_lts, as_ltu;

    // Operation decode for the shared datapath units
    always_comb begin
        fn       = alu_func_e'(func_i);
        sub_en   = (fn == FN_SUBS) || (fn == FN_SUBW) ||
                   (fn == FN_LTS)  || (fn == FN_LTU);
        sh_left  = (fn == FN_SHL);
        sh_arith = (fn == FN_SHRA);
        bw_op    = bitwise_op_e'(func_i[1:0]);
    end

    alu_addsub #(.WIDTH(WIDTH)) u_addsub (
        .a_i           (opa_i),
        .b_i           (opb_i),
        .sub_i         (sub_en),
        .sum_o         (as_sum),
        .ovf_o         (as_ovf),
        .lt_signed_o   (as_lts),
        .lt_unsigned_o (as_ltu)
    );

    alu_bitwise #(.WIDTH(WIDTH)) u_bitwise (
        .a_i  (opa_i),
        .b_i  (opb_i),
        .op_i (bw_op),
        .y_o  (bw_y)
    );

    alu_shifter #(.WIDTH(WIDTH), .SHAMT_W(SHAMT_W)) u_shifter (
        .d_i     (opa_i),
        .amt_i   (shamt_i),
        .left_i  (sh_left),
        .arith_i (sh_arith),
        .y_o     (sh_y)
    );

    always_comb begin
        out_d = '0;
        case (fn)
            FN_ADDS, FN_SUBS: begin
                out_d.result = as_sum;
                out_d.ovf    = as_ovf;
            end
            FN_ADDW, FN_SUBW:              out_d.result = as_sum;
            FN_AND, FN_OR, FN_XOR, FN_NOR: out_d.result = bw_y;
            FN_LTS: out_d.result = {{(WIDTH-1){1'b0}}, as_lts};
            FN_LTU: out_d.result = {{(WIDTH-1){1'b0}}, as_ltu};
            FN_SHL, FN_SHR, FN_SHRA:       out_d.result = sh_y;
            FN_UPIM: out_d.result = {opb_i[IMM_W-1:0], {IMM_W{1'b0}}};
            default: out_d = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_q <= '0;
        end else begin
            out_q <= out_d;
        end
    end

    assign result_o = out_q.result;
    assign ovf_o    = out_q.ovf;

endmodule

// File: rtl/alu_core_chk.sv
module alu_core_chk #(
    parameter int WIDTH = 32
) (
    input logic                     clk,
    input logic                     rst_n,
    input logic [5:0]               func_i,
    input logic [WIDTH-1:0]         opa_i,
    input logic [WIDTH-1:0]         opb_i,
    input logic [$clog2(WIDTH)-1:0] shamt_i,
    input logic [WIDTH-1:0]         result_o,
    input logic                     ovf_o
);

    localparam int IMM_W = WIDTH / 2;

    function automatic logic known_code(input logic [5:0] f);
        return f inside {6'h00, 6'h02, 6'h03, 6'h0F, 6'h20, 6'h21, 6'h22,
                         6'h23, 6'h24, 6'h25, 6'h26, 6'h27, 6'h2A, 6'h2B};
    endfunction

    // R4: exception only after a signed add or subtract
    p_no_overflow_r4: assert property (@(posedge clk) disable iff (!rst_n)
        ovf_o |-> ($past(func_i) == 6'h20 || $past(func_i) == 6'h22));

    // R7, R8: comparisons give a single-bit value
    p_cmp_bool_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(func_i) == 6'h2A || $past(func_i) == 6'h2B) |->
        (result_o[WIDTH-1:1] == '0 && !ovf_o));

    // R9: a zero count passes the operand through
    p_shift_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(func_i) == 6'h02 && $past(shamt_i) == '0) |->
        (result_o == $past(opa_i)));

    // R10: arithmetic right shift keeps the sign bit
    p_sra_sign_r10: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(func_i) == 6'h03) |-> (result_o[WIDTH-1] == $past(opa_i[WIDTH-1])));

    // R11: upper constant lands in the high half
    p_upper_imm_r11: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(func_i) == 6'h0F) |->
        (result_o == {$past(opb_i[IMM_W-1:0]), {IMM_W{1'b0}}}));

    // R12: unlisted codes give zero and no exception
    p_unknown_zero_r12: assert property (@(posedge clk) disable iff (!rst_n)
        !known_code($past(func_i)) |-> (result_o == '0 && !ovf_o));

endmodule

bind alu_core alu_core_chk #(.WIDTH(WIDTH)) u_chk (.*);

// File: tb/tb_alu_core.sv
module tb_alu_core;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [5:0]  func_i = 6'h20;
    logic [31:0] opa_i = 32'd1;
    logic [31:0] opb_i = 32'd2;
    logic [4:0]  shamt_i = 5'd0;
    logic [31:0] result_o;
    logic        ovf_o;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    alu_core dut (
        .clk      (clk),
        .rst_n    (rst_n),
        .func_i   (func_i),
        .opa_i    (opa_i),
        .opb_i    (opb_i),
        .shamt_i  (shamt_i),
        .result_o (result_o),
        .ovf_o    (ovf_o)
    );

    task automatic compare(input string req, input logic [31:0] exp_res,
                           input logic exp_ovf);
        checks++;
        if (result_o !== exp_res || ovf_o !== exp_ovf) begin
            errors++;
            $display("FAIL %s: result=%h ovf=%b expected result=%h ovf=%b",
                     req, result_o, ovf_o, exp_res, exp_ovf);
        end
    endtask

    // Drive on a falling edge, sample on the next falling edge
    task automatic run(input string req, input logic [5:0] f,
                       input logic [31:0] a, input logic [31:0] b,
                       input logic [4:0] sh, input logic [31:0] exp_res,
                       input logic exp_ovf);
        @(negedge clk);
        func_i = f; opa_i = a; opb_i = b; shamt_i = sh;
        @(negedge clk);
        compare(req, exp_res, exp_ovf);
    endtask

    task automatic t_reset;
        func_i = 6'h20; opa_i = 32'h7FFF_FFFF; opb_i = 32'd1;
        repeat (3) @(negedge clk);
        compare("R1 reset", 32'h0, 1'b0);
        rst_n = 1'b1;
    endtask

    task automatic t_add;
        run("R2 add", 6'h20, 32'd5, 32'd7, 5'd3, 32'd12, 1'b0);
        run("R2 add negatives", 6'h20, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 5'd0, 32'hFFFF_FFFE, 1'b0);
        run("R2 unsigned add wrap", 6'h21, 32'hFFFF_FFFF, 32'd1, 5'd0, 32'h0, 1'b0);
    endtask

    task automatic t_sub;
        run("R3 sub", 6'h22, 32'd10, 32'd3, 5'd0, 32'd7, 1'b0);
        run("R3 unsigned sub wrap", 6'h23, 32'd0, 32'd1, 5'd0, 32'hFFFF_FFFF, 1'b0);
    endtask

    task automatic t_overflow;
        run("R4 signed add overflow", 6'h20, 32'h7FFF_FFFF, 32'd1, 5'd0, 32'h8000_0000, 1'b1);
        run("R4 unsigned add same bits", 6'h21, 32'h7FFF_FFFF, 32'd1, 5'd0, 32'h8000_0000, 1'b0);
        run("R4 signed add neg overflow", 6'h20, 32'h8000_0000, 32'h8000_0000, 5'd0, 32'h0, 1'b1);
        run("R4 signed sub overflow", 6'h22, 32'h8000_0000, 32'd1, 5'd0, 32'h7FFF_FFFF, 1'b1);
        run("R4 unsigned sub same bits", 6'h23, 32'h8000_0000, 32'd1, 5'd0, 32'h7FFF_FFFF, 1'b0);
    endtask

    task automatic t_bitwise;
        run("R5 and", 6'h24, 32'hF0F0_1234, 32'h0FF0_FF00, 5'd0, 32'h00F0_1200, 1'b0);
        run("R5 or", 6'h25, 32'hF0F0_1234, 32'h0FF0_FF00, 5'd0, 32'hFFF0_FF34, 1'b0);
        run("R5 xor", 6'h26, 32'hF0F0_1234, 32'h0FF0_FF00, 5'd0, 32'hFF00_ED34, 1'b0);
        run("R6 nor", 6'h27, 32'hF0F0_1234, 32'h0FF0_FF00, 5'd0, 32'h000F_00CB, 1'b0);
    endtask

    task automatic t_compare;
        run("R7 signed less", 6'h2A, 32'hFFFF_FFFF, 32'd1, 5'd0, 32'd1, 1'b0);
        run("R7 signed not less", 6'h2A, 32'd1, 32'hFFFF_FFFF, 5'd0, 32'd0, 1'b0);
        run("R7 signed equal", 6'h2A, 32'd9, 32'd9, 5'd0, 32'd0, 1'b0);
        run("R7 signed limits", 6'h2A, 32'h8000_0000, 32'h7FFF_FFFF, 5'd0, 32'd1, 1'b0);
        run("R7 signed limits rev", 6'h2A, 32'h7FFF_FFFF, 32'h8000_0000, 5'd0, 32'd0, 1'b0);
        run("R8 unsigned not less", 6'h2B, 32'hFFFF_FFFF, 32'd1, 5'd0, 32'd0, 1'b0);
        run("R8 unsigned less", 6'h2B, 32'd1, 32'hFFFF_FFFF, 5'd0, 32'd1, 1'b0);
    endtask

    task automatic t_shift;
        run("R9 left by 1", 6'h00, 32'h8000_0001, 32'h0, 5'd1, 32'h0000_0002, 1'b0);
        run("R9 left by 31", 6'h00, 32'h0000_0001, 32'h0, 5'd31, 32'h8000_0000, 1'b0);
        run("R9 right by 31", 6'h02, 32'h8000_0000, 32'h0, 5'd31, 32'h0000_0001, 1'b0);
        run("R9 right by 0", 6'h02, 32'hDEAD_BEEF, 32'h0, 5'd0, 32'hDEAD_BEEF, 1'b0);
        run("R9 right zero fill", 6'h02, 32'hF000_0000, 32'h0, 5'd4, 32'h0F00_0000, 1'b0);
        run("R10 arith neg", 6'h03, 32'h8000_0000, 32'h0, 5'd4, 32'hF800_0000, 1'b0);
        run("R10 arith pos", 6'h03, 32'h7000_0000, 32'h0, 5'd4, 32'h0700_0000, 1'b0);
        run("R10 arith by 31", 6'h03, 32'h8000_0000, 32'h0, 5'd31, 32'hFFFF_FFFF, 1'b0);
    endtask

    task automatic t_upper;
        run("R11 upper constant", 6'h0F, 32'h5555_5555, 32'hABCD_1234, 5'd7, 32'h1234_0000, 1'b0);
    endtask

    task automatic t_unknown;
        run("R4 setup overflow", 6'h20, 32'h7FFF_FFFF, 32'h7FFF_FFFF, 5'd0, 32'hFFFF_FFFE, 1'b1);
        run("R12 unlisted code", 6'h3F, 32'h1234_5678, 32'h9ABC_DEF0, 5'd5, 32'h0, 1'b0);
        run("R12 unlisted code 0x01", 6'h01, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 5'd1, 32'h0, 1'b0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: run did not complete");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        t_reset();
        t_add();
        t_sub();
        t_overflow();
        t_bitwise();
        t_compare();
        t_shift();
        t_upper();
        t_unknown();
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule